// File: doc/BRIEF.md
# Boundary-Pausing DMA Address Generator

This block produces the system-memory byte address for a single-address host DMA engine. The engine moves fixed-size data blocks between a card data buffer and system memory. Software loads a start address, a block size, a block count and a boundary code, then issues a start command. Each 32-bit data beat that the bus master accepts moves the address forward by four bytes. The block keeps a running count of the bytes and the whole blocks it has moved.

System memory may only be contiguous within a window of 4 KB shifted left by the boundary code. While DMA mode is enabled and a beat carries the address across such a window edge, the generator stops requesting beats. It raises a sticky interrupt and holds until software writes a fresh system address, and then continues from that address. When the final beat of the transfer lands exactly on a window edge, the transfer completes without pausing.

Top module: `dma_bnd_addr_gen`

## Requirements
- R1: After reset, the boundary code, block size, block count, DMA enable, address, byte count and block count are all 0. The block is idle, does not request beats, and its interrupt and done outputs are low.
- R2: A write to register select 1 loads the block size from data bits 11:0 and the boundary code from bits 14:12. Bit 15 and the bits above it are ignored. Register select 2 loads the block count from bits 15:0.
- R3: While a transfer is running or paused, writes to the block size, boundary code, block count and DMA enable are ignored.
- R4: A control write (select 3) with bit 1 set, issued while idle, starts a transfer in the next cycle, with busy and dma_req high. The start is ignored if the block size or the block count is 0. Bit 0 of the same write sets the DMA enable.
- R5: Each beat accepted (beat_valid high while dma_req is high) moves dma_addr forward by 4 in the next cycle. beat_valid has no effect while dma_req is low.
- R6: With DMA enabled and boundary code n, a beat that is not the last one and whose next address has its low 12+n bits all zero makes the block pause in the next cycle: paused high, dma_req low, address held.
- R7: Entering a pause sets dma_irq, which stays high until a control write with bit 2 set clears it. Each boundary crossing sets it once only.
- R8: A write to the system address (select 0) while paused loads dma_addr and resumes beat requests in the next cycle. While idle it only loads the address. While running it is ignored.
- R9: With DMA disabled, boundary crossings neither pause the transfer nor raise dma_irq.
- R10: bytes_done rises by 4 for each accepted beat. blocks_done rises by 1 each time the bytes moved within the current block reach the block size (a multiple of 4). Both counts clear when a transfer starts.
- R11: After the beat that completes the last block, xfer_done pulses for exactly one cycle and the block returns to idle. A last beat that lands on a window edge completes the transfer without pausing or raising dma_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 size/boundary, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| beat_valid | input | 1 | Bus master moves one 32-bit beat at dma_addr |
| dma_addr | output | 32 | Current system byte address |
| dma_req | output | 1 | Generator is running and wants beats |
| dma_irq | output | 1 | Sticky boundary interrupt |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| busy | output | 1 | Transfer running or paused |
| paused | output | 1 | Halted at a boundary |
| bytes_done | output | 32 | Bytes moved in this transfer |
| blocks_done | output | 16 | Whole blocks moved in this transfer |
| cfg_bnd | output | 3 | Boundary code readback |
| cfg_blk_size | output | 12 | Block size readback |
| cfg_blk_cnt | output | 16 | Block count readback |
| cfg_dma_en | output | 1 | DMA enable readback |

## Verification
Every result of this block appears one clock edge after its cause. A register write becomes visible on the readback ports, and a start raises busy and dma_req, after that edge. An accepted beat produces the new address, the updated counts, and any pause with its interrupt or the done pulse, all in the same following cycle. The done pulse falls one edge later. The bench drives each stimulus at a falling edge and checks at the next falling edge, so exactly one registering edge lies between them. The scoreboard monitor compares the issued address 1 ns after the falling edge at which the beat is presented, before the edge that accepts it.

// File: rtl/dma_bnd_pkg.sv
package dma_bnd_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int SIZE_W     = 12;
    localparam int BND_W      = 3;
    localparam int CNT_W      = 16;
    localparam int BYTES_W    = 32;
    localparam int BEAT_BYTES = 4;
    localparam int BEAT_LOG2  = $clog2(BEAT_BYTES);
    localparam int BASE_LOG2  = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_SYSADDR = 2'd0,
        SEL_BLKCFG  = 2'd1,
        SEL_BLKCNT  = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BND_W-1:0]  bnd;
        logic [SIZE_W-1:0] size;
    } blk_cfg_t;

    typedef struct packed {
        logic irq_clr;
        logic start;
        logic dma_en;
    } ctrl_wr_t;

    function automatic logic cfg_startable(input blk_cfg_t cfg, input logic [CNT_W-1:0] cnt);
        return (cfg.size != '0) && (cnt != '0);
    endfunction

endpackage

// File: rtl/dma_bnd_regs.sv
module dma_bnd_regs
    import dma_bnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              idle,
    input  logic              paused,
    output blk_cfg_t          cfg,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic              dma_en,
    output logic              start_pulse,
    output logic              irq_clr,
    output logic              sys_wr,
    output logic [ADDR_W-1:0] sys_data
);

    reg_sel_e sel;
    ctrl_wr_t ctl;
    logic     wr_cfg, wr_cnt, wr_ctl;

    assign sel    = reg_sel_e'(reg_sel);
    assign ctl    = ctrl_wr_t'(reg_wdata[2:0]);
    assign wr_cfg = reg_wr && (sel == SEL_BLKCFG) && idle;
    assign wr_cnt = reg_wr && (sel == SEL_BLKCNT) && idle;
    assign wr_ctl = reg_wr && (sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            blk_cnt <= '0;
            dma_en  <= 1'b0;
        end else begin
            if (wr_cfg) cfg     <= blk_cfg_t'(reg_wdata[SIZE_W+BND_W-1:0]);
            if (wr_cnt) blk_cnt <= reg_wdata[CNT_W-1:0];
            if (wr_ctl && idle) dma_en <= ctl.dma_en;
        end
    end

    assign start_pulse = wr_ctl && idle && ctl.start && cfg_startable(cfg, blk_cnt);
    assign irq_clr     = wr_ctl && ctl.irq_clr;
    assign sys_wr      = reg_wr && (sel == SEL_SYSADDR) && (idle || paused);
    assign sys_data    = reg_wdata[ADDR_W-1:0];

    // Configuration must not move while a transfer owns it
    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (!idle && reg_wr && (reg_sel != 2'd0)) |=> ($stable(cfg) && $stable(blk_cnt) && $stable(dma_en)));

endmodule

// File: rtl/dma_bnd_detect.sv
module dma_bnd_detect #(
    parameter int ADDR_W    = 32,
    parameter int BND_W     = 3,
    parameter int BASE_LOG2 = 12,
    parameter int BEAT_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BND_W-1:0]  code,
    output logic              at_edge
);

    localparam int NCODES  = 1 << BND_W;
    localparam int TOP_BIT = BASE_LOG2 + NCODES - 2;

    logic [NCODES-1:0] hit;

    // One window per code: the beat at addr crosses the edge when every
    // bit inside the window above the beat offset is set.
    for (genvar c = 0; c < NCODES; c++) begin : g_win
        localparam int HI = BASE_LOG2 + c - 1;
        assign hit[c] = &addr[HI:BEAT_LOG2];
    end

    assign at_edge = hit[code];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[BEAT_LOG2-1:0], addr[ADDR_W-1:TOP_BIT+1]};

endmodule

// File: rtl/dma_bnd_count.sv
module dma_bnd_count #(
    parameter int SIZE_W     = 12,
    parameter int CNT_W      = 16,
    parameter int BYTES_W    = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               accept,
    input  logic [SIZE_W-1:0]  blk_size,
    input  logic [CNT_W-1:0]   blk_cnt,
    output logic [BYTES_W-1:0] bytes_done,
    output logic [CNT_W-1:0]   blocks_done,
    output logic               last_beat
);

    localparam int IN_W = SIZE_W + 1;

    logic [IN_W-1:0] in_blk, in_blk_nx;
    logic            blk_end;

    assign in_blk_nx = in_blk + IN_W'(BEAT_BYTES);
    assign blk_end   = in_blk_nx >= {1'b0, blk_size};
    assign last_beat = blk_end && ((blocks_done + CNT_W'(1)) == blk_cnt);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            in_blk      <= '0;
            bytes_done  <= '0;
            blocks_done <= '0;
        end else if (accept) begin
            bytes_done <= bytes_done + BYTES_W'(BEAT_BYTES);
            if (blk_end) begin
                in_blk      <= '0;
                blocks_done <= blocks_done + CNT_W'(1);
            end else begin
                in_blk <= in_blk_nx;
            end
        end
    end

    assert_bytes_step_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && !clear) |=> (bytes_done == $past(bytes_done) + BYTES_W'(BEAT_BYTES)));

    assert_blocks_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && !clear) |=> (blocks_done - $past(blocks_done) <= CNT_W'(1)));

endmodule

// File: rtl/dma_bnd_seq.sv
module dma_bnd_seq
    import dma_bnd_pkg::*;
#(
    parameter int AW  = 32,
    parameter int BYT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sys_wr,
    input  logic [AW-1:0] sys_data,
    input  logic          irq_clr,
    input  logic          dma_en,
    input  logic          beat_valid,
    input  logic          at_edge,
    input  logic          last_beat,
    output seq_state_e    state,
    output logic [AW-1:0] addr,
    output logic          accept,
    output logic          irq,
    output logic          done
);

    logic pause_now;

    assign accept    = (state == ST_RUN) && beat_valid;
    assign pause_now = accept && !last_beat && dma_en && at_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            addr  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (sys_wr) addr <= sys_data;
            unique case (state)
                ST_IDLE: if (start) state <= ST_RUN;
                ST_RUN: begin
                    if (accept) begin
                        addr <= addr + AW'(BYT);
                        if (last_beat) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else if (pause_now) begin
                            state <= ST_PAUSE;
                        end
                    end
                end
                ST_PAUSE: if (sys_wr) state <= ST_RUN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (pause_now) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (addr == $past(addr) + AW'(BYT)));

    assert_addr_hold_run_R8: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN) && !accept) |=> $stable(addr));

    assert_pause_has_irq_R7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PAUSE) && ($past(state) == ST_RUN)) |-> irq);

    assert_irq_needs_dma_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(dma_en && accept));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> ((state == ST_IDLE) && !$rose(irq)));

endmodule

// File: rtl/dma_bnd_addr_gen.sv
module dma_bnd_addr_gen
    import dma_bnd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                beat_valid,
    output logic [ADDR_W-1:0]   dma_addr,
    output logic                dma_req,
    output logic                dma_irq,
    output logic                xfer_done,
    output logic                busy,
    output logic                paused,
    output logic [BYTES_W-1:0]  bytes_done,
    output logic [CNT_W-1:0]    blocks_done,
    output logic [BND_W-1:0]    cfg_bnd,
    output logic [SIZE_W-1:0]   cfg_blk_size,
    output logic [CNT_W-1:0]    cfg_blk_cnt,
    output logic                cfg_dma_en
);

    seq_state_e        state;
    blk_cfg_t          cfg;
    logic [CNT_W-1:0]  blk_cnt;
    logic              dma_en, start_pulse, irq_clr, sys_wr;
    logic [ADDR_W-1:0] sys_data;
    logic              at_edge, last_beat, accept;

    dma_bnd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .idle        (state == ST_IDLE),
        .paused      (state == ST_PAUSE),
        .cfg         (cfg),
        .blk_cnt     (blk_cnt),
        .dma_en      (dma_en),
        .start_pulse (start_pulse),
        .irq_clr     (irq_clr),
        .sys_wr      (sys_wr),
        .sys_data    (sys_data)
    );

    dma_bnd_detect #(
        .ADDR_W    (ADDR_W),
        .BND_W     (BND_W),
        .BASE_LOG2 (BASE_LOG2),
        .BEAT_LOG2 (BEAT_LOG2)
    ) u_detect (
        .addr    (dma_addr),
        .code    (cfg.bnd),
        .at_edge (at_edge)
    );

    dma_bnd_count #(
        .SIZE_W     (SIZE_W),
        .CNT_W      (CNT_W),
        .BYTES_W    (BYTES_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_count (
        .clk         (clk),
        .rst         (rst),
        .clear       (start_pulse),
        .accept      (accept),
        .blk_size    (cfg.size),
        .blk_cnt     (blk_cnt),
        .bytes_done  (bytes_done),
        .blocks_done (blocks_done),
        .last_beat   (last_beat)
    );

    dma_bnd_seq #(
        .AW  (ADDR_W),
        .BYT (BEAT_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start_pulse),
        .sys_wr     (sys_wr),
        .sys_data   (sys_data),
        .irq_clr    (irq_clr),
        .dma_en     (dma_en),
        .beat_valid (beat_valid),
        .at_edge    (at_edge),
        .last_beat  (last_beat),
        .state      (state),
        .addr       (dma_addr),
        .accept     (accept),
        .irq        (dma_irq),
        .done       (xfer_done)
    );

    assign dma_req      = (state == ST_RUN);
    assign busy         = (state != ST_IDLE);
    assign paused       = (state == ST_PAUSE);
    assign cfg_bnd      = cfg.bnd;
    assign cfg_blk_size = cfg.size;
    assign cfg_blk_cnt  = blk_cnt;
    assign cfg_dma_en   = dma_en;

    assert_pause_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (paused && beat_valid) |=> ($stable(dma_addr) && $stable(bytes_done)));

endmodule

// File: tb/dma_bnd_addr_gen_tb_top.sv
module dma_bnd_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        beat_valid = 1'b0;
    logic [31:0] dma_addr;
    logic        dma_req, dma_irq, xfer_done, busy, paused;
    logic [31:0] bytes_done;
    logic [15:0] blocks_done;
    logic [2:0]  cfg_bnd;
    logic [11:0] cfg_blk_size;
    logic [15:0] cfg_blk_cnt;
    logic        cfg_dma_en;

    always #5 clk = ~clk;

    dma_bnd_addr_gen dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .beat_valid(beat_valid), .dma_addr(dma_addr), .dma_req(dma_req), .dma_irq(dma_irq),
        .xfer_done(xfer_done), .busy(busy), .paused(paused), .bytes_done(bytes_done),
        .blocks_done(blocks_done), .cfg_bnd(cfg_bnd), .cfg_blk_size(cfg_blk_size),
        .cfg_blk_cnt(cfg_blk_cnt), .cfg_dma_en(cfg_dma_en)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_addr = '0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            if (exp_q.size() != 0) begin
                n_chk++; n_fail++;
                $display("FAIL R5 scoreboard: actual %0d beats left expected 0", exp_q.size());
            end
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: one beat; when the model expects it accepted, push its address
    task automatic beat(input bit accepted);
        @(negedge clk);
        if (accepted) begin
            exp_q.push_back(exp_addr);
            exp_addr += 32'd4;
        end
        beat_valid = 1'b1;
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        wr(2'd0, a);
        exp_addr = a;
    endtask

    // Monitor: compare the address issued with each accepted beat
    always begin
        @(negedge clk);
        #1;
        if (!rst && beat_valid && dma_req) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 beat: actual 0x%0h expected none", dma_addr);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (dma_addr !== e) begin
                    n_fail++;
                    $display("FAIL R5 beat addr: actual 0x%0h expected 0x%0h", dma_addr, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "req", {31'd0, dma_req}, 32'd0);
        chk("R1", "irq", {31'd0, dma_irq}, 32'd0);
        chk("R1", "addr", dma_addr, 32'd0);
        chk("R1", "cfg", {cfg_dma_en, cfg_bnd, cfg_blk_size, cfg_blk_cnt}, 32'd0);

        // R2 field decode, bit 15 ignored
        wr(2'd1, 32'hFFFF_9010);
        chk("R2", "bnd", {29'd0, cfg_bnd}, 32'd1);
        chk("R2", "size", {20'd0, cfg_blk_size}, 32'h10);
        wr(2'd1, 32'h0000_0010);
        chk("R2", "bnd0", {29'd0, cfg_bnd}, 32'd0);

        // R4 start with zero count ignored
        wr(2'd3, 32'h3);
        chk("R4", "zero-count start", {31'd0, busy}, 32'd0);
        wr(2'd2, 32'hABCD_0003);
        chk("R2", "count", {16'd0, cfg_blk_cnt}, 32'd3);

        // Scenario A: 4 KB window, 3 blocks of 16 bytes from 0xFE0
        set_addr(32'h0000_0FE0);
        wr(2'd3, 32'h3);
        chk("R4", "busy", {31'd0, busy}, 32'd1);
        chk("R4", "req", {31'd0, dma_req}, 32'd1);
        wr(2'd1, 32'h0000_2040);
        chk("R3", "size locked", {20'd0, cfg_blk_size}, 32'h10);
        wr(2'd2, 32'd9);
        chk("R3", "count locked", {16'd0, cfg_blk_cnt}, 32'd3);
        wr(2'd3, 32'h0);
        chk("R3", "enable locked", {31'd0, cfg_dma_en}, 32'd1);
        wr(2'd0, 32'h5555_0000);
        chk("R8", "addr write in run", dma_addr, 32'h0000_0FE0);
        for (int i = 0; i < 8; i++) beat(1'b1);
        chk("R6", "paused", {31'd0, paused}, 32'd1);
        chk("R6", "req low", {31'd0, dma_req}, 32'd0);
        chk("R6", "addr at edge", dma_addr, 32'h0000_1000);
        chk("R7", "irq", {31'd0, dma_irq}, 32'd1);
        chk("R10", "bytes", bytes_done, 32'd32);
        chk("R10", "blocks", {16'd0, blocks_done}, 32'd2);
        beat(1'b0);
        chk("R5", "beat in pause", dma_addr, 32'h0000_1000);
        chk("R7", "irq held", {31'd0, dma_irq}, 32'd1);
        wr(2'd3, 32'h4);
        chk("R7", "irq cleared", {31'd0, dma_irq}, 32'd0);
        beat(1'b0);
        chk("R7", "no re-raise", {31'd0, dma_irq}, 32'd0);
        set_addr(32'h2000_0000);
        chk("R8", "resume addr", dma_addr, 32'h2000_0000);
        chk("R8", "resume req", {31'd0, dma_req}, 32'd1);
        for (int i = 0; i < 4; i++) beat(1'b1);
        chk("R11", "done pulse", {31'd0, xfer_done}, 32'd1);
        chk("R11", "idle", {31'd0, busy}, 32'd0);
        chk("R10", "final bytes", bytes_done, 32'd48);
        chk("R10", "final blocks", {16'd0, blocks_done}, 32'd3);
        @(negedge clk);
        chk("R11", "done one cycle", {31'd0, xfer_done}, 32'd0);

        // Scenario B: DMA disabled, crossing 0x1000 without pause
        wr(2'd1, 32'h0000_0008);
        wr(2'd2, 32'd2);
        set_addr(32'h0000_0FF8);
        wr(2'd3, 32'h2);
        chk("R10", "counts cleared", bytes_done, 32'd0);
        beat(1'b1);
        beat(1'b1);
        chk("R9", "no pause", {31'd0, paused}, 32'd0);
        chk("R9", "no irq", {31'd0, dma_irq}, 32'd0);
        chk("R9", "still req", {31'd0, dma_req}, 32'd1);
        beat(1'b1);
        beat(1'b1);
        chk("R11", "done B", {31'd0, xfer_done}, 32'd1);
        chk("R5", "addr B", dma_addr, 32'h0000_1008);

        // Scenario C: 8 KB window, passing 0x1000 does not pause
        wr(2'd1, 32'h0000_1020);
        wr(2'd2, 32'd1);
        set_addr(32'h0000_0FF0);
        wr(2'd3, 32'h3);
        for (int i = 0; i < 8; i++) beat(1'b1);
        chk("R6", "8K no pause at 4K", {31'd0, dma_irq}, 32'd0);
        chk("R11", "done C", {31'd0, xfer_done}, 32'd1);

        // Scenario D: last beat lands on an 8 KB edge
        wr(2'd1, 32'h0000_1010);
        set_addr(32'h0000_1FF0);
        wr(2'd3, 32'h3);
        for (int i = 0; i < 4; i++) beat(1'b1);
        chk("R11", "done on edge", {31'd0, xfer_done}, 32'd1);
        chk("R11", "no irq on edge", {31'd0, dma_irq}, 32'd0);
        chk("R11", "no pause on edge", {31'd0, paused}, 32'd0);
        chk("R5", "addr D", dma_addr, 32'h0000_2000);

        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule